// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is a serial configuration port that runs entirely in the system clock domain. It has three pins: a serial clock, a serial data line and a latch enable. All three pass through two-flop synchronizers, and their edges are detected on the system clock. On each rising edge of the serial clock, one data bit enters an 18-bit shift register, most significant bit first.

On a rising edge of latch enable, the two bits shifted in last act as an address. They select one of four holding latches, and the 16 bits shifted in before them are written into that latch. The selected latch also raises a one-cycle update strobe.

Each latch feeds an active register that drives a divider or control counter. A new value reaches the active register only when that counter reports its terminal count. Until then, the counter keeps running on its previous setting.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, every holding latch, every active register and every update strobe reads zero.
- R2: Each rising edge of the serial clock shifts the data pin level into the shift register, most significant bit first. Serial clock edges without a latch enable edge change no holding latch.
- R3: On a rising edge of latch enable, the last two bits shifted in select the latch: value k selects latch k, for k from 0 to 3. The 16 bits shifted in before those two are written into that latch, with the first bit shifted in as bit 15.
- R4: A latch-enable commit leaves the three unselected holding latches unchanged.
- R5: A holding latch changes only on a latch-enable rising edge. Holding latch enable high or low with no rising edge commits nothing.
- R6: When more than 18 bits are shifted before a commit, only the last 18 are used.
- R7: When fewer than 18 bits are shifted, the older bits remaining in the shift register fill the upper positions. No error is signalled.
- R8: Each commit pulses the update strobe of the written latch, and only that strobe, for exactly one system clock cycle.
- R9: Active register k loads holding latch k only at a system clock edge where its terminal-count input is high. At all other edges it holds its value.
- R10: A committed value appears on the holding latch outputs three system clock cycles after the latch enable pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_dat_i | input | 1 | Serial data pin (asynchronous) |
| ser_le_i | input | 1 | Latch enable pin (asynchronous) |
| tc_i | input | 4 | Per-counter terminal-count flags; bit k belongs to counter k |
| shadow_o | output | 64 | Holding latches; latch k occupies bits [16k+15:16k] |
| active_o | output | 64 | Active registers; register k occupies bits [16k+15:16k] |
| upd_o | output | 4 | One-cycle update strobes, one bit per latch |

## Verification
A wrong shift-register state shows up at the first commit after it. The bad value lands either in the wrong latch or with wrong bits, and it is visible on the holding latch outputs three cycles after latch enable rises. A wrong address decode shows in the same cycle in two ways: an unselected latch changes, and the wrong strobe bit pulses. A fault in the active stage stays hidden until the next terminal-count pulse for that counter. One cycle after that pulse, the active output differs from the holding latch value.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned FRAME_W  = 18;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DATA_W   = FRAME_W - ADDR_W;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam int unsigned SYNC_STAGES = 2;

  // pin positions within the synchronized bundle
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_DAT = 1;
  localparam int unsigned PIN_LE  = 2;
  localparam int unsigned NUM_PINS = 3;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // a rising edge cannot repeat on consecutive cycles
  for (genvar g = 0; g < int'(WIDTH); g++) begin : g_edge_chk
    p_edge_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
  parameter int unsigned FRAME_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign frame_o = sr_q;

  p_shift_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(frame_o));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic [NUM_REGS-1:0]          tc_i,
  output logic [NUM_REGS*DATA_W-1:0]   shadow_o,
  output logic [NUM_REGS*DATA_W-1:0]   active_o,
  output logic [NUM_REGS-1:0]          upd_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] shadow_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] active_q;
  logic [NUM_REGS-1:0]             upd_q;

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    logic sel;
    assign sel = commit_i && (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        upd_q[g]    <= 1'b0;
      end else begin
        upd_q[g] <= sel;
        if (sel) shadow_q[g] <= data_i;
      end
    end

    // counter picks up the held value only at its terminal count
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      active_q[g] <= '0;
      else if (tc_i[g]) active_q[g] <= shadow_q[g];
    end

    assign shadow_o[g*DATA_W +: DATA_W] = shadow_q[g];
    assign active_o[g*DATA_W +: DATA_W] = active_q[g];

    p_hold_unwritten_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_q[g] |-> $stable(shadow_q[g]));
    p_upd_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_q[g] |=> !upd_q[g]);
    p_act_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tc_i[g] |=> $stable(active_q[g]));
    p_act_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_i[g] |=> (active_q[g] == $past(shadow_q[g])));
  end

  assign upd_o = upd_q;

  p_upd_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_q));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned P_FRAME_W = FRAME_W,
  parameter int unsigned P_ADDR_W  = ADDR_W,
  localparam int unsigned P_DATA_W = P_FRAME_W - P_ADDR_W,
  localparam int unsigned P_NREGS  = 1 << P_ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ser_clk_i,
  input  logic                          ser_dat_i,
  input  logic                          ser_le_i,
  input  logic [P_NREGS-1:0]            tc_i,
  output logic [P_NREGS*P_DATA_W-1:0]   shadow_o,
  output logic [P_NREGS*P_DATA_W-1:0]   active_o,
  output logic [P_NREGS-1:0]            upd_o
);
  logic [NUM_PINS-1:0]  pins, pin_sync, pin_rise;
  logic [P_FRAME_W-1:0] frame;
  logic                 unused_pins;

  assign pins[PIN_CLK] = ser_clk_i;
  assign pins[PIN_DAT] = ser_dat_i;
  assign pins[PIN_LE]  = ser_le_i;

  cfg_pin_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .sync_o (pin_sync),
    .rise_o (pin_rise)
  );

  assign unused_pins = ^{pin_sync[PIN_CLK], pin_sync[PIN_LE], pin_rise[PIN_DAT]};

  cfg_frame_shifter #(
    .FRAME_W (P_FRAME_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (pin_rise[PIN_CLK]),
    .bit_i   (pin_sync[PIN_DAT]),
    .frame_o (frame)
  );

  cfg_latch_bank #(
    .DATA_W (P_DATA_W),
    .ADDR_W (P_ADDR_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (pin_rise[PIN_LE]),
    .addr_i   (frame[P_ADDR_W-1:0]),
    .data_i   (frame[P_FRAME_W-1:P_ADDR_W]),
    .tc_i     (tc_i),
    .shadow_o (shadow_o),
    .active_o (active_o),
    .upd_o    (upd_o)
  );

  p_no_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rise[PIN_LE] |=> (upd_o == '0));
endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [3:0]  tc = '0;
  logic [63:0] shadow, active;
  logic [3:0]  upd;

  int checks = 0, errors = 0;
  logic [17:0] m_sr = '0;
  logic [15:0] exp_sh [4];
  logic [15:0] exp_act[4];
  int          exp_upd[4];
  int          obs_upd[4];
  logic [3:0]  prev_upd = '0;

  always #10 clk = ~clk;

  cfg_serial_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_le_i(sle), .tc_i(tc), .shadow_o(shadow), .active_o(active), .upd_o(upd)
  );

  // strobe monitor: counts pulses, flags any pulse wider than one cycle (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (upd[k]) obs_upd[k]++;
        if (upd[k] && prev_upd[k]) begin
          errors++;
          $display("FAIL R8 strobe %0d wide: actual 2+ cycles expected 1", k);
        end
      end
    end
    prev_upd = upd;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic [15:0] a[4]);
    return {a[3], a[2], a[1], a[0]};
  endfunction

  task automatic check_all(input string req);
    chk(shadow == pack(exp_sh), req, shadow, pack(exp_sh));
    chk(active == pack(exp_act), {req, " active"}, active, pack(exp_act));
    for (int k = 0; k < 4; k++)
      chk(obs_upd[k] == exp_upd[k], {req, " R8 strobe count"}, 64'(obs_upd[k]), 64'(exp_upd[k]));
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk); sdat = b;
    repeat (3) @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk);
    m_sr = {m_sr[16:0], b};
  endtask

  task automatic ser_word(input logic [31:0] val, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) ser_bit(val[i]);
  endtask

  // commit and check exactly three cycles later (R10)
  task automatic pulse_le(input string req);
    int a;
    a = int'(m_sr[1:0]);
    @(negedge clk); sle = 1'b1;
    @(negedge clk); #1;
    chk(shadow == pack(exp_sh), "R10 early", shadow, pack(exp_sh));
    exp_sh[a] = m_sr[17:2];
    exp_upd[a]++;
    repeat (2) @(negedge clk); #1;
    check_all(req);
    @(negedge clk); sle = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tc_pulse(input int k);
    @(negedge clk); #1;
    chk(active == pack(exp_act), "R9 hold before tc", active, pack(exp_act));
    tc[k] = 1'b1;
    @(negedge clk); tc[k] = 1'b0;
    exp_act[k] = exp_sh[k];
    #1 chk(active == pack(exp_act), "R9 load at tc", active, pack(exp_act));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin
      exp_sh[k] = '0; exp_act[k] = '0; exp_upd[k] = 0; obs_upd[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_all("R1 reset");

    // directed: one frame per address, R3 / R4
    ser_word({16'hA5C3, 2'd0}, 18); pulse_le("R3 addr0 R4");
    ser_word({16'h1234, 2'd1}, 18); pulse_le("R3 addr1 R4");
    ser_word({16'hFFFF, 2'd2}, 18); pulse_le("R3 addr2 R4");
    ser_word({16'h0001, 2'd3}, 18); pulse_le("R3 addr3 R4");

    // R2/R5: serial clocks, no latch-enable edge, nothing commits
    ser_word({16'hDEAD, 2'd1}, 18);
    repeat (4) @(negedge clk); #1;
    check_all("R2 R5 no commit");
    // R5: latch enable held high through shifting commits only once
    @(negedge clk); sle = 1'b1;
    repeat (3) @(negedge clk);
    exp_sh[1] = m_sr[17:2]; exp_upd[1]++;
    ser_word({16'hBEEF, 2'd1}, 18);
    #1 check_all("R5 le held high");
    @(negedge clk); sle = 1'b0;
    repeat (3) @(negedge clk);

    // R6: 22 bits, only last 18 matter
    ser_word({4'hF, 16'h0F0F, 2'd2}, 22); pulse_le("R6 overlong");
    // R7: short frame of 6 bits keeps stale upper bits
    ser_word({4'h9, 2'd3}, 6); pulse_le("R7 short");

    // R9: terminal count transfers
    for (int k = 0; k < 4; k++) tc_pulse(k);
    ser_word({16'h7777, 2'd0}, 18); pulse_le("R9 pre");
    tc_pulse(1);
    tc_pulse(0);

    // random frames, lengths, and terminal counts
    for (int it = 0; it < 30; it++) begin
      int n;
      n = (it % 5 == 0) ? 10 + int'($urandom_range(0, 14)) : 18;
      ser_word($urandom, n);
      pulse_le("R3 R4 R6 R7 random");
      if ($urandom_range(0, 2) == 0) tc_pulse(int'($urandom_range(0, 3)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule